// File: doc/BRIEF.md
# Long-Mode Transition Consistency Checker

This block holds the control bits that govern entry into a 64-bit extended execution mode. These are paging enable, physical-address-extension enable and the long-mode enable request, plus a long-mode-active flag that the block derives from them. Software-side logic presents a write request that carries new values for the three writable bits. The block checks the request against cross-register ordering rules. It then either commits the whole request on the next clock edge or leaves every bit as it was and raises a one-cycle general-protection fault pulse.

The block also keeps the L and D attribute bits of the current code segment and the type tag of the task register. The type tag is an input. From these bits and the long-mode-active flag it reports the current execution mode together with the default operand and address sizes. It flags the reserved L=1, D=1 combination as invalid.

Top module: `lm_transition_ctl`

## Requirements
- R1: A write whose long-mode-enable value differs from the current one is rejected while paging is currently enabled.
- R2: A write that turns paging on (current paging 0, requested 1) with requested long-mode enable 1 and requested physical-address extension 0 is rejected.
- R3: While long mode is active and physical-address extension is currently 1, a write requesting physical-address extension 0 is rejected.
- R4: An activating write is one with current paging 0, requested paging 1 and requested long-mode enable 1. An activating write is rejected when the stored code-segment L bit is 1.
- R5: An activating write is rejected unless `tr_type` equals the 16-bit TSS type tag parameter (default 4'h3).
- R6: A rejected write leaves paging, physical-address extension, long-mode enable and long-mode active unchanged and drives `gp_fault` high for exactly one cycle after the request edge. An accepted write updates the bits on that edge with `gp_fault` low.
- R7: On an accepted write, long mode active becomes 1 when paging and long-mode enable are both requested 1, and becomes 0 when paging is requested 0.
- R8: With long mode active, L=1 and D=0 gives mode code 4 (64-bit), operand size code 1 (32 bits) and address size code 2 (64 bits).
- R9: With long mode active and L=0, the mode is compatibility mode. D=1 gives mode 3 with size codes 1/1, and D=0 gives mode 2 with size codes 0/0.
- R10: With long mode active, L=1 and D=1 gives mode code 7, both size codes 3 and `cs_invalid`=1. In every other case `cs_invalid` is 0.
- R11: With long mode inactive, L is ignored. D=0 gives mode 0 with size codes 0/0, and D=1 gives mode 1 with size codes 1/1.
- R12: A synchronous reset clears all four control bits and both code-segment bits, so the outputs show mode 0 with size codes 0/0 and `gp_fault` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Control-bit write request |
| wr_pg | input | 1 | Requested paging enable |
| wr_pae | input | 1 | Requested physical-address extension |
| wr_lme | input | 1 | Requested long-mode enable |
| cs_ld | input | 1 | Load code-segment attribute bits |
| cs_l_in | input | 1 | New code-segment L bit |
| cs_d_in | input | 1 | New code-segment D bit |
| tr_type | input | 4 | Task register descriptor type tag |
| pg | output | 1 | Paging enable |
| pae | output | 1 | Physical-address extension |
| lme | output | 1 | Long-mode enable |
| lma | output | 1 | Long mode active |
| gp_fault | output | 1 | One-cycle fault on a rejected write |
| mode | output | 3 | Execution mode code (0,1,2,3,4,7) |
| op_size | output | 2 | Default operand size code (0=16, 1=32, 2=64, 3=none) |
| addr_size | output | 2 | Default address size code (0=16, 1=32, 2=64, 3=none) |
| cs_invalid | output | 1 | Reserved code-segment combination in long mode |

## Verification
The bench starts from every reachable control state and sweeps all eight write values against both L-bit values and a valid and an invalid task type. This catches a design that tests the requested paging bit instead of the current one when it decides whether a long-mode-enable change is allowed. The sweep shows whether a design checks the L bit or the task type on every write rather than only on the activating one, since it would then fault spuriously. It also shows whether a design applies part of a rejected request, because the bits would move. The mode sweep covers all four L/D pairs with long mode active and inactive. This exposes a decoder that honours L outside long mode or misses the reserved pair.

// File: rtl/lm_pkg.sv
package lm_pkg;

  typedef enum logic [2:0] {
    MODE_LEG16  = 3'd0,
    MODE_LEG32  = 3'd1,
    MODE_CMP16  = 3'd2,
    MODE_CMP32  = 3'd3,
    MODE_LONG64 = 3'd4,
    MODE_RSVD   = 3'd7
  } exec_mode_e;

  localparam logic [1:0] SZ16   = 2'd0;
  localparam logic [1:0] SZ32   = 2'd1;
  localparam logic [1:0] SZ64   = 2'd2;
  localparam logic [1:0] SZNONE = 2'd3;

  typedef struct packed {
    logic pg;
    logic pae;
    logic lme;
  } ctl_req_t;

  function automatic exec_mode_e mode_of(input logic act, input logic l, input logic d);
    if (!act)          return d ? MODE_LEG32 : MODE_LEG16;
    else if (!l)       return d ? MODE_CMP32 : MODE_CMP16;
    else if (!d)       return MODE_LONG64;
    else               return MODE_RSVD;
  endfunction

  function automatic logic [1:0] opsz_of(input exec_mode_e m);
    case (m)
      MODE_LEG16, MODE_CMP16:              return SZ16;
      MODE_LEG32, MODE_CMP32, MODE_LONG64: return SZ32;
      default:                             return SZNONE;
    endcase
  endfunction

  function automatic logic [1:0] adsz_of(input exec_mode_e m);
    case (m)
      MODE_LEG16, MODE_CMP16: return SZ16;
      MODE_LEG32, MODE_CMP32: return SZ32;
      MODE_LONG64:            return SZ64;
      default:                return SZNONE;
    endcase
  endfunction

endpackage

// File: rtl/lm_write_rules.sv
module lm_write_rules
  import lm_pkg::*;
#(
  parameter int TYPE_W = 4,
  parameter logic [TYPE_W-1:0] TSS16_TYPE = 4'h3
) (
  input  logic              cur_pg,
  input  logic              cur_pae,
  input  logic              cur_lme,
  input  logic              cur_lma,
  input  ctl_req_t          req,
  input  logic              seg_l,
  input  logic [TYPE_W-1:0] tr_type,
  output logic              activating,
  output logic              v_lme_chg,
  output logic              v_pae_order,
  output logic              v_pae_clear,
  output logic              v_seg_l,
  output logic              v_tss,
  output logic              reject
);

  logic pg_turning_on;

  always_comb begin
    pg_turning_on = !cur_pg && req.pg;
    activating    = pg_turning_on && req.lme;
    v_lme_chg     = cur_pg && (cur_lme != req.lme);
    v_pae_order   = pg_turning_on && req.lme && !req.pae;
    v_pae_clear   = cur_lma && cur_pae && !req.pae;
    v_seg_l       = activating && seg_l;
    v_tss         = activating && (tr_type != TSS16_TYPE);
    reject        = v_lme_chg | v_pae_order | v_pae_clear | v_seg_l | v_tss;
  end

endmodule

// File: rtl/lm_ctrl_regs.sv
module lm_ctrl_regs
  import lm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wr_en,
  input  ctl_req_t req,
  input  logic     reject,
  output logic     pg,
  output logic     pae,
  output logic     lme,
  output logic     lma,
  output logic     gp_fault
);

  logic commit;
  logic refuse;

  assign commit = wr_en && !reject;
  assign refuse = wr_en && reject;

  always_ff @(posedge clk) begin
    if (rst) begin
      pg       <= 1'b0;
      pae      <= 1'b0;
      lme      <= 1'b0;
      lma      <= 1'b0;
      gp_fault <= 1'b0;
    end else begin
      gp_fault <= refuse;
      if (commit) begin
        pg  <= req.pg;
        pae <= req.pae;
        lme <= req.lme;
        lma <= req.pg && req.lme;
      end
    end
  end

  // R6
  fault_freezes_bits_chk: assert property (@(posedge clk) disable iff (rst)
    gp_fault |-> $stable({pg, pae, lme, lma}));

  // R6
  idle_holds_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en) && !$past(rst)) |-> $stable({pg, pae, lme, lma}));

  // R7
  active_needs_paging_chk: assert property (@(posedge clk) disable iff (rst)
    lma |-> (pg && lme));

  // R2
  active_needs_pae_chk: assert property (@(posedge clk) disable iff (rst)
    lma |-> pae);

  // R1
  lme_locked_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(pg) && pg && !$past(rst)) |-> $stable(lme));

endmodule

// File: rtl/lm_mode_decode.sv
module lm_mode_decode
  import lm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_ld,
  input  logic       cs_l_in,
  input  logic       cs_d_in,
  input  logic       lma,
  output logic       seg_l,
  output logic [2:0] mode,
  output logic [1:0] op_size,
  output logic [1:0] addr_size,
  output logic       cs_invalid
);

  logic       seg_d;
  exec_mode_e cur_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_l <= 1'b0;
      seg_d <= 1'b0;
    end else if (cs_ld) begin
      seg_l <= cs_l_in;
      seg_d <= cs_d_in;
    end
  end

  always_comb begin
    cur_mode   = mode_of(lma, seg_l, seg_d);
    mode       = cur_mode;
    op_size    = opsz_of(cur_mode);
    addr_size  = adsz_of(cur_mode);
    cs_invalid = (cur_mode == MODE_RSVD);
  end

  // R10
  invalid_only_long_chk: assert property (@(posedge clk) disable iff (rst)
    cs_invalid |-> (lma && op_size == SZNONE && addr_size == SZNONE));

  // R11
  legacy_no_64_chk: assert property (@(posedge clk) disable iff (rst)
    !lma |-> (addr_size != SZ64 && !cs_invalid));

  // R8
  wide_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_size == SZ64) |-> (lma && op_size == SZ32));

endmodule

// File: rtl/lm_transition_ctl.sv
module lm_transition_ctl
  import lm_pkg::*;
#(
  parameter int TYPE_W = 4,
  parameter logic [TYPE_W-1:0] TSS16_TYPE = 4'h3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_pg,
  input  logic              wr_pae,
  input  logic              wr_lme,
  input  logic              cs_ld,
  input  logic              cs_l_in,
  input  logic              cs_d_in,
  input  logic [TYPE_W-1:0] tr_type,
  output logic              pg,
  output logic              pae,
  output logic              lme,
  output logic              lma,
  output logic              gp_fault,
  output logic [2:0]        mode,
  output logic [1:0]        op_size,
  output logic [1:0]        addr_size,
  output logic              cs_invalid
);

  ctl_req_t req;
  logic     seg_l;
  logic     activating;
  logic     v_lme_chg, v_pae_order, v_pae_clear, v_seg_l, v_tss;
  logic     reject;

  assign req = '{pg: wr_pg, pae: wr_pae, lme: wr_lme};

  lm_write_rules #(.TYPE_W(TYPE_W), .TSS16_TYPE(TSS16_TYPE)) u_rules (
    .cur_pg(pg), .cur_pae(pae), .cur_lme(lme), .cur_lma(lma),
    .req(req), .seg_l(seg_l), .tr_type(tr_type),
    .activating(activating),
    .v_lme_chg(v_lme_chg), .v_pae_order(v_pae_order), .v_pae_clear(v_pae_clear),
    .v_seg_l(v_seg_l), .v_tss(v_tss), .reject(reject)
  );

  lm_ctrl_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .req(req), .reject(reject),
    .pg(pg), .pae(pae), .lme(lme), .lma(lma), .gp_fault(gp_fault)
  );

  lm_mode_decode u_dec (
    .clk(clk), .rst(rst), .cs_ld(cs_ld), .cs_l_in(cs_l_in), .cs_d_in(cs_d_in),
    .lma(lma), .seg_l(seg_l), .mode(mode), .op_size(op_size),
    .addr_size(addr_size), .cs_invalid(cs_invalid)
  );

  // R4
  seg_l_blocks_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && activating && seg_l) |=> (gp_fault && !lma));

  // R5
  tss_blocks_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && activating && tr_type != TSS16_TYPE) |=> (gp_fault && !lma));

  // R3
  pae_held_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && lma && !wr_pae) |=> (pae && gp_fault));

endmodule

// File: tb/test_lm_transition_ctl.sv
module test_lm_transition_ctl;

  localparam time CLK_HALF = 10ns;
  localparam logic [3:0] GOOD_TR = 4'h3;
  localparam logic [3:0] BAD_TR  = 4'hB;

  logic clk = 0;
  logic rst = 1;
  logic wr_en = 0, wr_pg = 0, wr_pae = 0, wr_lme = 0;
  logic cs_ld = 0, cs_l_in = 0, cs_d_in = 0;
  logic [3:0] tr_type = GOOD_TR;
  logic pg, pae, lme, lma, gp_fault, cs_invalid;
  logic [2:0] mode;
  logic [1:0] op_size, addr_size;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #CLK_HALF clk = ~clk;

  lm_transition_ctl i_lm_transition_ctl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_pg(wr_pg), .wr_pae(wr_pae),
    .wr_lme(wr_lme), .cs_ld(cs_ld), .cs_l_in(cs_l_in), .cs_d_in(cs_d_in),
    .tr_type(tr_type), .pg(pg), .pae(pae), .lme(lme), .lma(lma),
    .gp_fault(gp_fault), .mode(mode), .op_size(op_size),
    .addr_size(addr_size), .cs_invalid(cs_invalid)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; wr_en = 0; cs_ld = 0;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  task automatic do_write(input logic p, input logic a, input logic l);
    @(negedge clk); wr_en = 1; wr_pg = p; wr_pae = a; wr_lme = l;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic load_cs(input logic l, input logic d);
    @(negedge clk); cs_ld = 1; cs_l_in = l; cs_d_in = d;
    @(negedge clk); cs_ld = 0;
  endtask

  // Expected fault from the rules R1..R5, stated per rule
  function automatic bit rule_fault(bit sp, bit sa, bit sl, bit sx,
                                    bit np, bit na, bit nl, bit csl, bit trok);
    bit entry;
    entry = (np & ~sp) & nl;
    if (sp && (sl != nl)) return 1;           // R1
    if (entry && !na) return 1;               // R2
    if (sx && sa && !na) return 1;            // R3
    if (entry && csl) return 1;               // R4
    if (entry && !trok) return 1;             // R5
    return 0;
  endfunction

  // Expected {mode, op, addr, invalid} from R8..R11
  function automatic logic [7:0] exp_mode(bit act, bit l, bit d);
    logic [2:0] m; logic [1:0] o, a; bit inv;
    inv = 0;
    if (!act) begin m = d ? 3'd1 : 3'd0; o = d ? 2'd1 : 2'd0; a = o; end
    else if (!l) begin m = d ? 3'd3 : 3'd2; o = d ? 2'd1 : 2'd0; a = o; end
    else if (!d) begin m = 3'd4; o = 2'd1; a = 2'd2; end
    else begin m = 3'd7; o = 2'd3; a = 2'd3; inv = 1; end
    return {m, o, a, inv};
  endfunction

  initial begin
    #(CLK_HALF * 2 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ep, ea, el, ex, f;
    do_reset();
    @(negedge clk);
    // R12
    check("R12 bits", {pg, pae, lme, lma, gp_fault}, 0);
    check("R12 mode", {mode, op_size, addr_size, cs_invalid}, 0);

    // Write sweep over reachable start states: R1..R7
    for (int s = 0; s < 8; s++) begin
      bit sp, sa, sl;
      sp = s[2]; sa = s[1]; sl = s[0];
      if (sp && sl && !sa) continue;
      for (int w = 0; w < 8; w++) begin
        for (int c = 0; c < 4; c++) begin
          bit csl, trok;
          csl = c[0]; trok = c[1];
          do_reset();
          tr_type = GOOD_TR;
          do_write(1'b0, sa, sl);
          if (sp) do_write(1'b1, sa, sl);
          ex = sp && sl;
          check("R7 setup", {pg, pae, lme, lma}, {sp, sa, sl, ex});
          load_cs(csl, 1'b0);
          tr_type = trok ? GOOD_TR : BAD_TR;
          f = rule_fault(sp, sa, sl, ex, w[2], w[1], w[0], csl, trok);
          do_write(w[2], w[1], w[0]);
          if (f) begin
            ep = sp; ea = sa; el = sl;
          end else begin
            ep = w[2]; ea = w[1]; el = w[0];
            ex = w[2] && w[0];
          end
          check("R1-5 fault", gp_fault, f);
          check("R6 R7 bits", {pg, pae, lme, lma}, {ep, ea, el, ex});
          @(negedge clk);
          check("R6 pulse", gp_fault, 0);
        end
      end
    end

    // Mode decode sweep: R8..R11
    tr_type = GOOD_TR;
    for (int act = 0; act < 2; act++) begin
      do_reset();
      if (act == 1) begin
        do_write(1'b0, 1'b1, 1'b1);
        do_write(1'b1, 1'b1, 1'b1);
      end
      check("R7 active", lma, act);
      for (int k = 0; k < 4; k++) begin
        load_cs(k[1], k[0]);
        if (act == 0)
          check("R11 decode", {mode, op_size, addr_size, cs_invalid}, exp_mode(0, k[1], k[0]));
        else if (k == 2)
          check("R8 decode", {mode, op_size, addr_size, cs_invalid}, exp_mode(1, k[1], k[0]));
        else if (k == 3)
          check("R10 decode", {mode, op_size, addr_size, cs_invalid}, exp_mode(1, k[1], k[0]));
        else
          check("R9 decode", {mode, op_size, addr_size, cs_invalid}, exp_mode(1, k[1], k[0]));
      end
    end

    // Leaving long mode by clearing paging: R7
    do_write(1'b0, 1'b1, 1'b1);
    check("R7 leave", {pg, lma, gp_fault}, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule